// File: doc/BRIEF.md
# Watchdog Timer with Timed Unlock

This block is a watchdog timer. It counts ticks of a slow clock-enable that stands in for a dedicated watchdog oscillator. When the count reaches the selected limit, it pulses a reset request. Software clears the count through a kick input before the limit is reached. Two static configuration inputs pick one of three safety levels. The safety level decides whether the watchdog starts enabled, whether it can be switched off, and whether the prescaler can be rewritten freely.

Changes that could weaken the watchdog are guarded by an unlock. First comes an unlock write with both the change-enable and enable fields set to 1. This opens a short window. A single later write with change-enable clear, arriving inside that window, may then clear the enable or replace the prescaler. Writes that arrive outside the window leave the guarded fields alone. A write that sets the enable is honoured at any level. A readback port shows the enable, the prescaler and whether the window is open.

Top module: `wdog_guard`

## Requirements
- R1: The level is 2 when `cfgAlwaysOn`=1, 0 when `cfgCompat`=1 and `cfgAlwaysOn`=0, and 1 when both are 0. After reset, `rdPsc`=0 and `rdChg`=0, and `rdEna` is 1 at level 2 and 0 at levels 0 and 1.
- R2: At level 2, `rdEna` stays 1 whatever is written, including inside an open window.
- R3: At levels 0 and 1, a write with `wrEna`=1 sets `rdEna` to 1 without any unlock.
- R4: At level 0, any write loads `wrPsc` into the prescaler, whether or not the window is open.
- R5: At levels 1 and 2, a write outside the window leaves `rdPsc` unchanged. A write with `wrChg`=0 inside the window loads `wrPsc`.
- R6: A write with `wrChg`=1 and `wrEna`=1 opens the window. `rdChg` then reads 1 for the next WIN_CYC (default 4) cycles, and writes landing on those WIN_CYC following clock edges count as inside the window.
- R7: At levels 0 and 1, a write with `wrEna`=0 clears `rdEna` only inside the window. Outside the window it is ignored.
- R8: Any write inside the window that is not itself an unlock closes the window, so `rdChg` reads 0 after it.
- R9: While enabled with `tick` held high, `wdReset` rises exactly 2^(BASE_EXP+P) cycles after the clock edge that cleared or enabled the counter, where P is the prescaler. The count then restarts from zero and repeats with the same period.
- R10: Each `wdReset` pulse lasts exactly one cycle.
- R11: `kick` clears the counter, so kicking at least once per period prevents any reset. While disabled, the counter is held at zero and `wdReset` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfgCompat | input | 1 | Static compatibility configuration input |
| cfgAlwaysOn | input | 1 | Static always-on configuration input |
| tick | input | 1 | Watchdog time-base clock enable |
| wrEn | input | 1 | Register write strobe |
| wrChg | input | 1 | Change-enable field of the write |
| wrEna | input | 1 | Enable field of the write |
| wrPsc | input | 3 | Prescaler field of the write |
| kick | input | 1 | Clears the timeout counter |
| rdChg | output | 1 | Window-open readback |
| rdEna | output | 1 | Enable readback |
| rdPsc | output | 3 | Prescaler readback |
| wdReset | output | 1 | One-cycle watchdog reset pulse |

## Verification
The hardest case to reach from the ports is a guarded write that lands on the final edge of the window, or on the edge just after it closes. The bench issues an unlock and then idles for a counted number of cycles before the second write. In one run the write lands on the fourth edge and must be taken. In another it lands on the fifth and must be dropped. Timeout periods are swept over every prescaler value at all three levels. The bench uses a small base exponent so that each period stays short enough to measure edge by edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PSC_W = 3;

  typedef enum logic [1:0] {
    LVL_FREE    = 2'd0,
    LVL_GUARDED = 2'd1,
    LVL_LOCKED  = 2'd2
  } safety_e;

  typedef struct packed {
    logic             run;
    logic             clr;
    logic [PSC_W-1:0] sel;
  } cnt_strobe_t;

  function automatic safety_e decodeLevel(input logic compat, input logic alwaysOn);
    if (alwaysOn)    return LVL_LOCKED;
    else if (compat) return LVL_FREE;
    else             return LVL_GUARDED;
  endfunction
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgCompat,
  input  logic             cfgAlwaysOn,
  input  logic             wrEn,
  input  logic             wrChg,
  input  logic             wrEna,
  input  logic [PSC_W-1:0] wrPsc,
  input  logic             kick,
  output cnt_strobe_t      strobe,
  output logic             rdChg,
  output logic             rdEna,
  output logic [PSC_W-1:0] rdPsc
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  safety_e          level;
  logic [WIN_W-1:0] winQ, winNext;
  logic             enaQ, enaNext;
  logic [PSC_W-1:0] pscQ, pscNext;
  logic             winOpen, unlockWr, plainWr;

  assign level    = decodeLevel(cfgCompat, cfgAlwaysOn);
  assign winOpen  = (winQ != '0);
  assign unlockWr = wrEn && wrChg && wrEna;
  assign plainWr  = wrEn && !unlockWr;

  always_comb begin
    enaNext = enaQ;
    pscNext = pscQ;
    winNext = winOpen ? winQ - WIN_W'(1) : '0;
    if (unlockWr) begin
      winNext = WIN_W'(WIN_CYC);
      enaNext = 1'b1;
      if (level == LVL_FREE) pscNext = wrPsc;
    end else if (plainWr) begin
      if (wrEna)        enaNext = 1'b1;
      else if (winOpen) enaNext = 1'b0;
      if (level == LVL_FREE || winOpen) pscNext = wrPsc;
      winNext = '0;
    end
    if (level == LVL_LOCKED) enaNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winQ <= '0;
      enaQ <= (level == LVL_LOCKED);
      pscQ <= '0;
    end else begin
      winQ <= winNext;
      enaQ <= enaNext;
      pscQ <= pscNext;
    end
  end

  assign strobe.run = enaQ;
  assign strobe.clr = kick || !enaQ;
  assign strobe.sel = pscQ;
  assign rdChg = winOpen;
  assign rdEna = enaQ;
  assign rdPsc = pscQ;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  cnt_strobe_t strobe,
  output logic        wdReset
);
  localparam int PSC_MAX = (1 << PSC_W) - 1;
  localparam int CNT_W   = BASE_EXP + PSC_MAX;

  logic [CNT_W-1:0] cnt, termVal;
  logic             atTerm, fireQ;

  assign termVal = {CNT_W{1'b1}} >> (PSC_W'(PSC_MAX) - strobe.sel);
  assign atTerm  = (cnt == termVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      fireQ <= 1'b0;
    end else begin
      fireQ <= 1'b0;
      if (strobe.clr) begin
        cnt <= '0;
      end else if (tick && strobe.run) begin
        if (atTerm) begin
          cnt   <= '0;
          fireQ <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign wdReset = fireQ;
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 14,
  parameter int WIN_CYC  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgCompat,
  input  logic       cfgAlwaysOn,
  input  logic       tick,
  input  logic       wrEn,
  input  logic       wrChg,
  input  logic       wrEna,
  input  logic [2:0] wrPsc,
  input  logic       kick,
  output logic       rdChg,
  output logic       rdEna,
  output logic [2:0] rdPsc,
  output logic       wdReset
);
  cnt_strobe_t strobe;

  wdog_ctrl #(.WIN_CYC(WIN_CYC)) ctrl (
    .clk(clk), .rst_n(rst_n), .cfgCompat(cfgCompat), .cfgAlwaysOn(cfgAlwaysOn),
    .wrEn(wrEn), .wrChg(wrChg), .wrEna(wrEna), .wrPsc(wrPsc), .kick(kick),
    .strobe(strobe), .rdChg(rdChg), .rdEna(rdEna), .rdPsc(rdPsc)
  );

  wdog_count #(.BASE_EXP(BASE_EXP)) count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe(strobe), .wdReset(wdReset)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfgCompat,
  input logic       cfgAlwaysOn,
  input logic       wrEn,
  input logic       wrChg,
  input logic       wrEna,
  input logic       rdChg,
  input logic       rdEna,
  input logic [2:0] rdPsc,
  input logic       wdReset
);
  AST_LOCKED_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    cfgAlwaysOn |-> rdEna);  // R2
  AST_UNLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrChg && wrEna) |=> rdChg);  // R6
  AST_DISABLE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdEna) |-> $past(rdChg && wrEn && !wrEna));  // R7
  AST_PSC_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdPsc) |-> ($past(wrEn) && ($past(rdChg) || $past(cfgCompat && !cfgAlwaysOn))));  // R5
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (rdChg && wrEn && !(wrChg && wrEna)) |=> !rdChg);  // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdReset |=> !wdReset);  // R10
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wdReset |-> $past(rdEna));  // R11
endmodule

bind wdog_guard wdog_guard_chk chk (
  .clk(clk), .rst_n(rst_n), .cfgCompat(cfgCompat), .cfgAlwaysOn(cfgAlwaysOn),
  .wrEn(wrEn), .wrChg(wrChg), .wrEna(wrEna), .rdChg(rdChg), .rdEna(rdEna),
  .rdPsc(rdPsc), .wdReset(wdReset)
);

// File: tb/wdog_guard_test.sv
module wdog_guard_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgCompat = 1'b0, cfgAlwaysOn = 1'b0, tick = 1'b1;
  logic wrEn = 1'b0, wrChg = 1'b0, wrEna = 1'b0, kick = 1'b0;
  logic [2:0] wrPsc = '0;
  logic rdChg, rdEna, wdReset;
  logic [2:0] rdPsc;
  int totalCnt = 0, failCnt = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_guard #(.BASE_EXP(BASE), .WIN_CYC(4)) uut (
    .clk(clk), .rst_n(rst_n), .cfgCompat(cfgCompat), .cfgAlwaysOn(cfgAlwaysOn),
    .tick(tick), .wrEn(wrEn), .wrChg(wrChg), .wrEna(wrEna), .wrPsc(wrPsc),
    .kick(kick), .rdChg(rdChg), .rdEna(rdEna), .rdPsc(rdPsc), .wdReset(wdReset)
  );

  task automatic check(input string req, input int act, input int exp);
    totalCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual %0d expected 150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic doRst(input logic c, input logic a);
    @(negedge clk);
    rst_n = 1'b0; cfgCompat = c; cfgAlwaysOn = a; wrEn = 1'b0; kick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // caller is at a negedge; the write lands on the next rising edge
  task automatic wr(input logic c, input logic e, input logic [2:0] p);
    wrEn = 1'b1; wrChg = c; wrEna = e; wrPsc = p;
    @(negedge clk);
    wrEn = 1'b0; wrChg = 1'b0; wrEna = 1'b0;
  endtask

  task automatic kickOnce();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic measure(input int len, input string tag);
    int hits = 0, first = -1, second = -1;
    for (int k = 1; k <= 2*len + 1; k++) begin
      @(negedge clk);
      if (wdReset) begin
        hits++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check({"R9 first ", tag}, first, len);
    check({"R9 second ", tag}, second, 2*len);
    check({"R10 pulses ", tag}, hits, 2);
  endtask

  initial begin
    int hits;
    // R1 reset states across all configuration combinations
    for (int m = 0; m < 4; m++) begin
      doRst(m[0], m[1]);
      check("R1 ena", int'(rdEna), m[1] ? 1 : 0);
      check("R1 psc", int'(rdPsc), 0);
      check("R1 chg", int'(rdChg), 0);
    end

    // R9 sweep of every prescaler at each level
    for (int lv = 0; lv < 3; lv++) begin
      doRst(lv == 0, lv == 2);
      for (int p = 0; p < 8; p++) begin
        if (lv == 0) begin
          wr(1'b0, 1'b1, 3'(p));
          check("R4 psc free", int'(rdPsc), p);
        end else begin
          wr(1'b1, 1'b1, 3'd0);
          wr(1'b0, 1'b1, 3'(p));
          check("R5 psc in window", int'(rdPsc), p);
        end
        kickOnce();
        measure(1 << (BASE + p), $sformatf("lvl%0d p%0d", lv, p));
      end
    end

    // level 1 directed
    doRst(1'b0, 1'b0);
    wr(1'b0, 1'b0, 3'd5);
    check("R5 psc outside window lvl1", int'(rdPsc), 0);
    wr(1'b0, 1'b1, 3'd3);
    check("R3 enable without unlock", int'(rdEna), 1);
    check("R5 psc ignored on enable write", int'(rdPsc), 0);
    wr(1'b0, 1'b0, 3'd0);
    check("R7 disable outside window ignored", int'(rdEna), 1);
    // R6 window length
    wr(1'b1, 1'b1, 3'd0);
    check("R6 chg edge1", int'(rdChg), 1);
    for (int i = 2; i <= 4; i++) begin
      @(negedge clk);
      check($sformatf("R6 chg edge%0d", i), int'(rdChg), 1);
    end
    @(negedge clk);
    check("R6 chg closed", int'(rdChg), 0);
    // write landing on the 5th edge is outside
    wr(1'b0, 1'b0, 3'd6);
    check("R7 disable after window ignored", int'(rdEna), 1);
    check("R5 psc after window ignored", int'(rdPsc), 0);
    // write landing on the 4th edge is inside
    wr(1'b1, 1'b1, 3'd0);
    repeat (3) @(negedge clk);
    wr(1'b0, 1'b1, 3'd6);
    check("R6 last-edge write accepted", int'(rdPsc), 6);
    check("R8 window closed by write", int'(rdChg), 0);
    wr(1'b0, 1'b1, 3'd2);
    check("R8 no second write", int'(rdPsc), 6);
    // R11 kick prevents reset
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b1, 3'd0);
    hits = 0;
    kick = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (wdReset) hits++;
    end
    kick = 1'b0;
    check("R11 kicked no reset", hits, 0);
    // R7 disable inside window, then quiet
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b0, 3'd0);
    check("R7 disable in window", int'(rdEna), 0);
    hits = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (wdReset) hits++;
    end
    check("R11 disabled no reset", hits, 0);
    wr(1'b0, 1'b1, 3'd0);
    measure(4, "from enable");

    // level 0 directed
    doRst(1'b1, 1'b0);
    wr(1'b0, 1'b0, 3'd7);
    check("R4 psc while disabled", int'(rdPsc), 7);
    check("R1 lvl0 still off", int'(rdEna), 0);
    wr(1'b0, 1'b1, 3'd1);
    check("R3 lvl0 enable", int'(rdEna), 1);
    wr(1'b0, 1'b0, 3'd1);
    check("R7 lvl0 disable outside ignored", int'(rdEna), 1);
    wr(1'b1, 1'b1, 3'd4);
    check("R4 psc on unlock write", int'(rdPsc), 4);
    wr(1'b0, 1'b0, 3'd4);
    check("R7 lvl0 disable in window", int'(rdEna), 0);

    // level 2 directed
    doRst(1'b1, 1'b1);
    wr(1'b0, 1'b0, 3'd3);
    check("R2 disable outside", int'(rdEna), 1);
    check("R5 lvl2 psc outside", int'(rdPsc), 0);
    wr(1'b1, 1'b1, 3'd0);
    wr(1'b0, 1'b0, 3'd3);
    check("R2 disable inside window", int'(rdEna), 1);
    check("R5 lvl2 psc inside", int'(rdPsc), 3);

    summary();
    $finish;
  end
endmodule